// File: doc/BRIEF.md
# Channel Loopback Path Selector

This block sits between the transmit side and the receive side of a multi-channel frame controller. Software names one transmit channel and one receive channel through a small register port. Bytes that the named transmit channel produces are copied into a short internal byte queue. When the named receive channel's slot arrives on the trunk side, the block ignores the trunk byte for that slot and delivers the oldest queued byte instead. Data sent from memory therefore comes back to memory, and the controller can test itself without an external line.

The two channel numbers are independent of each other. Each side holds at most one selection, and a new write replaces the old one. Channels that belong to a grouped multi-slot channel cannot be looped: such a request is refused and a sticky error flag is raised. Every receive slot leaves the block one cycle after it enters, whether it was looped or not. When the queue overflows, the oldest byte is discarded. When the queue is empty, the looped slot carries an idle byte of all ones. Reset clears both selections, empties the queue and clears both flags.

Top module: `chan_loop_sel`

## Requirements
- R1: After reset, both loop selections are off, cfg_err and buf_ovf are 0 and rx_vld is 0.
- R2: A write with cfg_wr=1, cfg_en=1 and cfg_side=0 (transmit) or 1 (receive) selects cfg_ch for that side from the next cycle on. A later write to the same side replaces the earlier channel, so each side holds one selection at most.
- R3: The transmit and receive selections are independent. Their channel numbers may differ, and a trunk slot whose channel equals only the transmit selection passes through unchanged.
- R4: A write with cfg_wr=1 and cfg_en=0 turns off the selection of the side named by cfg_side. That receive channel then passes trunk bytes again.
- R5: A set request for a channel whose bit in hyper_map is 1 is refused. Both selections stay unchanged, and cfg_err becomes 1 and stays 1 until reset.
- R6: A trunk slot that is not looped appears on rx_vld/rx_ch/rx_byte exactly one cycle later with its byte unchanged. A cycle with trk_vld=0 gives rx_vld=0 one cycle later.
- R7: A trunk slot on the selected receive channel outputs, one cycle later, the oldest queued byte in push order, and its trunk byte is ignored.
- R8: Only tx bytes whose tx_ch equals an active transmit selection enter the queue. All other tx bytes are ignored.
- R9: A looped slot that finds the queue empty outputs 0xFF. A push in that same cycle is not forwarded.
- R10: The queue holds 4 bytes. A push into a full queue with no pop in the same cycle discards the oldest byte and sets buf_ovf, which stays 1 until reset.
- R11: A push and a looped read in the same cycle on a full queue discard nothing and leave buf_ovf unchanged.
- R12: A reset in the middle of traffic turns off both selections and empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_side | input | 1 | 0 = transmit selection, 1 = receive selection |
| cfg_en | input | 1 | 1 = set the selection to cfg_ch, 0 = turn it off |
| cfg_ch | input | 5 | Channel number for a set request |
| hyper_map | input | 32 | One bit per channel; 1 marks a channel that is part of a grouped channel |
| tx_vld | input | 1 | A transmit byte is present |
| tx_ch | input | 5 | Channel of the transmit byte |
| tx_byte | input | 8 | Transmit byte |
| trk_vld | input | 1 | A trunk receive slot is present |
| trk_ch | input | 5 | Channel of the trunk slot |
| trk_byte | input | 8 | Trunk receive byte |
| rx_vld | output | 1 | Output slot valid |
| rx_ch | output | 5 | Output slot channel |
| rx_byte | output | 8 | Output byte (trunk, queued or idle) |
| loop_tx_on | output | 1 | Transmit selection active |
| loop_tx_ch | output | 5 | Selected transmit channel |
| loop_rx_on | output | 1 | Receive selection active |
| loop_rx_ch | output | 5 | Selected receive channel |
| cfg_err | output | 1 | Sticky flag for a refused request |
| buf_ovf | output | 1 | Sticky flag for a queue overflow |

## Verification
The assertions assume that hyper_map stays constant while a set request is being applied. They also assume that cfg_ch, tx_ch and trk_ch always name a channel that exists, so indexing and comparing them never produces an unknown. The bench drives hyper_map as a fixed pattern and keeps every channel number below 32. It changes all inputs only on the falling clock edge, so every strobe is stable for a full cycle around the rising edge.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;
  typedef enum logic {
    SIDE_TX = 1'b0,
    SIDE_RX = 1'b1
  } side_e;
endpackage

// File: rtl/lbsel_rst_sync.sv
module lbsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_ns <= meta_q;
    end
  end
endmodule

// File: rtl/lbsel_cfg.sv
module lbsel_cfg
  import lbsel_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_side,
  input  logic              cfg_en,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [NUM_CH-1:0] hyper_map,
  output logic              tx_on,
  output logic [CHW-1:0]    tx_ch,
  output logic              rx_on,
  output logic [CHW-1:0]    rx_ch,
  output logic              err
);
  localparam int NSIDE = 2;

  logic              refuse, accept;
  logic [NSIDE-1:0]  on_q, on_d, upd;
  logic [CHW-1:0]    ch_q [NSIDE];
  logic [CHW-1:0]    ch_d [NSIDE];
  logic              err_d, err_q;

  always_comb begin
    refuse = cfg_wr && cfg_en && hyper_map[cfg_ch];
    accept = cfg_wr && !refuse;
    err_d  = err_q | refuse;
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    always_comb begin
      upd[s]  = accept && (cfg_side == s[0]);
      on_d[s] = cfg_en;
      ch_d[s] = cfg_en ? cfg_ch : ch_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_q[s] <= 1'b0;
        ch_q[s] <= '0;
      end else if (upd[s]) begin
        on_q[s] <= on_d[s];
        ch_q[s] <= ch_d[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign tx_on = on_q[SIDE_TX];
  assign tx_ch = ch_q[SIDE_TX];
  assign rx_on = on_q[SIDE_RX];
  assign rx_ch = ch_q[SIDE_RX];
  assign err   = err_q;

  assert_set_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_en && !hyper_map[cfg_ch] && cfg_side == SIDE_TX)
      |=> (tx_on && tx_ch == $past(cfg_ch)));

  assert_clear_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_en && cfg_side == SIDE_RX) |=> !rx_on);

  assert_refuse_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_en && hyper_map[cfg_ch])
      |=> (err && $stable(tx_on) && $stable(rx_on) && $stable(tx_ch) && $stable(rx_ch)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/lbsel_fifo.sv
module lbsel_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, pop, drop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full  = (cnt_q == CW'(DEPTH));
    empty = (cnt_q == '0);
    pop   = pop_req && !empty;
    drop  = push && full && !pop;
    head  = mem[rd_q];

    rd_d  = (pop || drop) ? ptr_inc(rd_q) : rd_q;
    wr_d  = push ? ptr_inc(wr_q) : wr_q;
    ovf_d = ovf_q | drop;

    unique case ({push, pop})
      2'b10:   cnt_d = full ? cnt_q : cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign ovf = ovf_q;

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_drop_oldest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop_req) |=> (ovf && cnt_q == CW'(DEPTH)));

  assert_swap_no_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_req && full && !ovf) |=> !ovf);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

// File: rtl/lbsel_rx_out.sv
module lbsel_rx_out #(
  parameter int DW  = 8,
  parameter int CHW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trk_vld,
  input  logic [CHW-1:0] trk_ch,
  input  logic [DW-1:0]  trk_byte,
  input  logic           loop_on,
  input  logic [CHW-1:0] loop_ch,
  input  logic           buf_empty,
  input  logic [DW-1:0]  buf_head,
  output logic           pop_req,
  output logic           rx_vld,
  output logic [CHW-1:0] rx_ch,
  output logic [DW-1:0]  rx_byte
);
  localparam logic [DW-1:0] IDLE = '1;

  logic          hit;
  logic [DW-1:0] byte_d;

  always_comb begin
    hit     = trk_vld && loop_on && (trk_ch == loop_ch);
    pop_req = hit;
    if (!hit)          byte_d = trk_byte;
    else if (buf_empty) byte_d = IDLE;
    else               byte_d = buf_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_vld  <= 1'b0;
      rx_ch   <= '0;
      rx_byte <= '0;
    end else begin
      rx_vld <= trk_vld;
      if (trk_vld) begin
        rx_ch   <= trk_ch;
        rx_byte <= byte_d;
      end
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_vld == $past(trk_vld)));

  assert_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_vld && !(loop_on && trk_ch == loop_ch))
      |=> (rx_byte == $past(trk_byte) && rx_ch == $past(trk_ch)));

  assert_idle_on_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_vld && loop_on && trk_ch == loop_ch && buf_empty) |=> (rx_byte == IDLE));
endmodule

// File: rtl/chan_loop_sel.sv
module chan_loop_sel #(
  parameter int NUM_CH = 32,
  parameter int DW     = 8,
  parameter int DEPTH  = 4,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_side,
  input  logic              cfg_en,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [NUM_CH-1:0] hyper_map,
  input  logic              tx_vld,
  input  logic [CHW-1:0]    tx_ch,
  input  logic [DW-1:0]     tx_byte,
  input  logic              trk_vld,
  input  logic [CHW-1:0]    trk_ch,
  input  logic [DW-1:0]     trk_byte,
  output logic              rx_vld,
  output logic [CHW-1:0]    rx_ch,
  output logic [DW-1:0]     rx_byte,
  output logic              loop_tx_on,
  output logic [CHW-1:0]    loop_tx_ch,
  output logic              loop_rx_on,
  output logic [CHW-1:0]    loop_rx_ch,
  output logic              cfg_err,
  output logic              buf_ovf
);
  logic          rst_ns;
  logic          push, pop_req, buf_empty;
  logic [DW-1:0] buf_head;

  lbsel_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  lbsel_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_ns),
    .cfg_wr    (cfg_wr),
    .cfg_side  (cfg_side),
    .cfg_en    (cfg_en),
    .cfg_ch    (cfg_ch),
    .hyper_map (hyper_map),
    .tx_on     (loop_tx_on),
    .tx_ch     (loop_tx_ch),
    .rx_on     (loop_rx_on),
    .rx_ch     (loop_rx_ch),
    .err       (cfg_err)
  );

  always_comb push = tx_vld && loop_tx_on && (tx_ch == loop_tx_ch);

  lbsel_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_ns),
    .push      (push),
    .push_data (tx_byte),
    .pop_req   (pop_req),
    .head      (buf_head),
    .empty     (buf_empty),
    .ovf       (buf_ovf)
  );

  lbsel_rx_out #(.DW(DW), .CHW(CHW)) u_out (
    .clk       (clk),
    .rst_n     (rst_ns),
    .trk_vld   (trk_vld),
    .trk_ch    (trk_ch),
    .trk_byte  (trk_byte),
    .loop_on   (loop_rx_on),
    .loop_ch   (loop_rx_ch),
    .buf_empty (buf_empty),
    .buf_head  (buf_head),
    .pop_req   (pop_req),
    .rx_vld    (rx_vld),
    .rx_ch     (rx_ch),
    .rx_byte   (rx_byte)
  );

  assert_only_tx_loop_enters_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (tx_vld && !loop_tx_on && buf_empty && !trk_vld) |=> buf_empty);
endmodule

// File: tb/tb_chan_loop_sel.sv
module tb_chan_loop_sel;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_side, cfg_en;
  logic [4:0] cfg_ch;
  logic [31:0] hyper_map;
  logic       tx_vld, trk_vld;
  logic [4:0] tx_ch, trk_ch;
  logic [7:0] tx_byte, trk_byte;
  logic       rx_vld, loop_tx_on, loop_rx_on, cfg_err, buf_ovf;
  logic [4:0] rx_ch, loop_tx_ch, loop_rx_ch;
  logic [7:0] rx_byte;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  chan_loop_sel dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_side(cfg_side), .cfg_en(cfg_en), .cfg_ch(cfg_ch),
    .hyper_map(hyper_map),
    .tx_vld(tx_vld), .tx_ch(tx_ch), .tx_byte(tx_byte),
    .trk_vld(trk_vld), .trk_ch(trk_ch), .trk_byte(trk_byte),
    .rx_vld(rx_vld), .rx_ch(rx_ch), .rx_byte(rx_byte),
    .loop_tx_on(loop_tx_on), .loop_tx_ch(loop_tx_ch),
    .loop_rx_on(loop_rx_on), .loop_rx_ch(loop_rx_ch),
    .cfg_err(cfg_err), .buf_ovf(buf_ovf)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic       cw; logic cs; logic ce; logic [4:0] cc;
    logic       tv; logic [4:0] tc; logic [7:0] tb;
    logic       kv; logic [4:0] kc; logic [7:0] kb;
    logic       ev; logic [4:0] ec; logic [7:0] eb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd6,  1'b1,1'b0,1'b1,5'd3,  1'b0,5'd0,8'h00, 1'b1,5'd5,8'hA1,  1'b1,5'd5,8'hA1}, // R6 pass, set tx 3
    '{4'd7,  1'b1,1'b1,1'b1,5'd9,  1'b1,5'd3,8'h11, 1'b1,5'd6,8'h55,  1'b1,5'd6,8'h55}, // R7 push 11, set rx 9
    '{4'd7,  1'b0,1'b0,1'b0,5'd0,  1'b1,5'd3,8'h22, 1'b1,5'd9,8'h66,  1'b1,5'd9,8'h11}, // R7 oldest first
    '{4'd8,  1'b0,1'b0,1'b0,5'd0,  1'b1,5'd4,8'h33, 1'b1,5'd9,8'h77,  1'b1,5'd9,8'h22}, // R8 ch4 ignored
    '{4'd9,  1'b0,1'b0,1'b0,5'd0,  1'b0,5'd0,8'h00, 1'b1,5'd9,8'h78,  1'b1,5'd9,8'hFF}, // R9 empty idle
    '{4'd3,  1'b0,1'b0,1'b0,5'd0,  1'b0,5'd0,8'h00, 1'b1,5'd3,8'h44,  1'b1,5'd3,8'h44}, // R3 tx ch on rx side
    '{4'd6,  1'b0,1'b0,1'b0,5'd0,  1'b0,5'd0,8'h00, 1'b0,5'd0,8'h00,  1'b0,5'd0,8'h00}, // R6 no slot
    '{4'd6,  1'b1,1'b0,1'b1,5'd21, 1'b0,5'd0,8'h00, 1'b1,5'd1,8'h5A,  1'b1,5'd1,8'h5A}, // R5 refuse tx 21
    '{4'd5,  1'b0,1'b0,1'b0,5'd0,  1'b1,5'd3,8'h88, 1'b0,5'd0,8'h00,  1'b0,5'd0,8'h00}, // R5 tx 3 kept
    '{4'd5,  1'b0,1'b0,1'b0,5'd0,  1'b0,5'd0,8'h00, 1'b1,5'd9,8'h10,  1'b1,5'd9,8'h88}, // R5 byte looped
    '{4'd9,  1'b1,1'b1,1'b1,5'd12, 1'b0,5'd0,8'h00, 1'b1,5'd9,8'h99,  1'b1,5'd9,8'hFF}, // R9, replace rx
    '{4'd2,  1'b0,1'b0,1'b0,5'd0,  1'b0,5'd0,8'h00, 1'b1,5'd9,8'h98,  1'b1,5'd9,8'h98}, // R2 ch9 released
    '{4'd2,  1'b0,1'b0,1'b0,5'd0,  1'b0,5'd0,8'h00, 1'b1,5'd12,8'h00, 1'b1,5'd12,8'hFF}, // R2 ch12 looped
    '{4'd4,  1'b1,1'b1,1'b0,5'd0,  1'b0,5'd0,8'h00, 1'b1,5'd12,8'h12, 1'b1,5'd12,8'hFF}, // R4 clear rx
    '{4'd4,  1'b0,1'b0,1'b0,5'd0,  1'b0,5'd0,8'h00, 1'b1,5'd12,8'h34, 1'b1,5'd12,8'h34}  // R4 passes again
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr = 0; cfg_side = 0; cfg_en = 0; cfg_ch = 0;
    tx_vld = 0; tx_ch = 0; tx_byte = 0;
    trk_vld = 0; trk_ch = 0; trk_byte = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_loop(input logic side, input logic [4:0] ch);
    cfg_wr = 1; cfg_side = side; cfg_en = 1; cfg_ch = ch;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic push(input logic [4:0] ch, input logic [7:0] b);
    tx_vld = 1; tx_ch = ch; tx_byte = b;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic slot(input logic [4:0] ch, input logic [7:0] exp, input string req);
    trk_vld = 1; trk_ch = ch; trk_byte = 8'hC3;
    @(negedge clk);
    idle_inputs();
    chk(rx_vld && rx_byte == exp, req, rx_byte, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    hyper_map = 32'h00F0_0000;
    do_reset();

    // R1 reset state
    chk(!loop_tx_on && !loop_rx_on, "R1 loops off", {loop_tx_on, loop_rx_on}, 0);
    chk(!cfg_err && !buf_ovf && !rx_vld, "R1 flags clear", {cfg_err, buf_ovf, rx_vld}, 0);

    for (int i = 0; i < NV; i++) begin
      cfg_wr = VEC[i].cw; cfg_side = VEC[i].cs; cfg_en = VEC[i].ce; cfg_ch = VEC[i].cc;
      tx_vld = VEC[i].tv; tx_ch = VEC[i].tc; tx_byte = VEC[i].tb;
      trk_vld = VEC[i].kv; trk_ch = VEC[i].kc; trk_byte = VEC[i].kb;
      @(negedge clk);
      total++;
      if (rx_vld !== VEC[i].ev ||
          (VEC[i].ev && (rx_ch !== VEC[i].ec || rx_byte !== VEC[i].eb))) begin
        bad++;
        $display("FAIL R%0d vec %0d actual=%0b/%0d/%0h expected=%0b/%0d/%0h",
                 VEC[i].rq, i, rx_vld, rx_ch, rx_byte, VEC[i].ev, VEC[i].ec, VEC[i].eb);
      end
    end
    idle_inputs();

    chk(loop_tx_on && loop_tx_ch == 5'd3, "R5 tx loop kept", loop_tx_ch, 3);
    chk(cfg_err, "R5 error sticky", cfg_err, 1);
    chk(!loop_rx_on, "R4 rx loop off", loop_rx_on, 0);
    chk(!buf_ovf, "R10 no overflow yet", buf_ovf, 0);

    // R11 full queue, push and pop together
    do_reset();
    set_loop(1'b0, 5'd2);
    set_loop(1'b1, 5'd7);
    chk(loop_tx_ch == 5'd2 && loop_rx_ch == 5'd7, "R3 differing channels",
        {loop_tx_ch, loop_rx_ch}, {5'd2, 5'd7});
    for (int k = 1; k <= 4; k++) push(5'd2, 8'hA0 + 8'(k));
    tx_vld = 1; tx_ch = 5'd2; tx_byte = 8'hA5;
    slot(5'd7, 8'hA1, "R11 swap head");
    chk(!buf_ovf, "R11 no overflow", buf_ovf, 0);
    for (int k = 2; k <= 5; k++) slot(5'd7, 8'hA0 + 8'(k), "R11 drain");

    // R10 overflow drops oldest
    do_reset();
    set_loop(1'b0, 5'd2);
    set_loop(1'b1, 5'd7);
    for (int k = 1; k <= 5; k++) push(5'd2, 8'(k));
    chk(buf_ovf, "R10 overflow flag", buf_ovf, 1);
    for (int k = 2; k <= 5; k++) slot(5'd7, 8'(k), "R10 order after drop");
    slot(5'd7, 8'hFF, "R9 empty after drain");
    chk(buf_ovf, "R10 flag sticky", buf_ovf, 1);

    // R12 reset mid-use
    push(5'd2, 8'h61);
    push(5'd2, 8'h62);
    do_reset();
    chk(!loop_tx_on && !loop_rx_on, "R12 loops cleared", {loop_tx_on, loop_rx_on}, 0);
    chk(!buf_ovf && !cfg_err, "R12 flags cleared", {buf_ovf, cfg_err}, 0);
    slot(5'd7, 8'hC3, "R12 rx passes after reset");
    set_loop(1'b1, 5'd7);
    slot(5'd7, 8'hFF, "R12 queue emptied");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule